// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns an integer held in a 64-bit general-purpose register value into a binary floating-point number. The integer may be signed or unsigned, 32 or 64 bits wide. The result may be double or single precision. A single-precision result is first rounded to the 32-bit format and then handed back widened to the 64-bit register layout. It also returns the status information an FP unit needs: an inexact flag, a flag that says the fraction was rounded up in magnitude, a 5-bit result class and an enable that says whether these status outputs should be committed at all.

One datapath serves every combination. It sign-extends or zero-extends the operand, takes the magnitude, finds the leading one with a priority encoder and normalises. It then rounds in parallel at double and single precision with guard, round and sticky bits, and picks one of the two. A 32-bit integer converted to double precision can never be inexact. That case drops the status enable, so the surrounding unit leaves its flags alone.

The converter has one register stage. A request presented with `in_valid` appears on the outputs on the next clock edge together with `out_valid`. The outputs hold their value while no request arrives.

Top module: `i2f_convert`

## Requirements
- R1: `int_kind` selects the source type: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. For codes 0 and 1, bits 63:32 of `src_int` have no effect on any output.
- R2: For codes 0 and 1 with `want_single`=0, the conversion is exact: `flag_update`=0, and `flag_inexact`, `flag_rnd_up` and `res_class` are all 0.
- R3: In every other case `flag_update`=1 and `res_class` reports the result: 5'b01000 positive normal, 5'b10000 negative normal, 5'b00010 positive zero.
- R4: A double result is the source value correctly rounded to a 53-bit significand (bias 1023), with ties going to the even significand under the nearest mode.
- R5: With `want_single`=1 the value is rounded to a 24-bit significand, then widened to the 64-bit layout, so `res_fp[28:0]` is always 0.
- R6: `rnd_mode` encoding: 2'b00 nearest-even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity. Toward zero never sets `flag_rnd_up`.
- R7: `flag_inexact` is 1 exactly when discarded bits were non-zero. `flag_rnd_up` is 1 exactly when rounding increased the magnitude, and it implies `flag_inexact`.
- R8: A carry out of the rounded significand increments the exponent and clears the fraction, for example 2^64-1 becoming 2^64.
- R9: A zero source yields +0.0 (all bits 0) with both flags 0.
- R10: The most negative value of each signed type converts exactly: -2^31 gives 0xC1E0000000000000 and -2^63 gives 0xC3E0000000000000.
- R11: Outputs update one clock after `in_valid`=1 and `out_valid` is 1 for exactly that cycle. While `in_valid`=0 the result outputs hold. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; captures a conversion |
| src_int | input | 64 | Integer operand |
| int_kind | input | 2 | Source integer type code |
| want_single | input | 1 | 1: single-precision result, 0: double |
| rnd_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result valid, one cycle after the request |
| res_fp | output | 64 | Result in 64-bit FP register layout |
| flag_inexact | output | 1 | Result was rounded |
| flag_rnd_up | output | 1 | Fraction was rounded up in magnitude |
| res_class | output | 5 | Result class code |
| flag_update | output | 1 | Status outputs are to be committed |

## Verification
Every internal decision of this block surfaces at the ports in the cycle right after the request. A wrong leading-one position shows as an exponent off by a power of two. A wrong guard or sticky tap shows as a last-place error or a missing inexact flag, and only for operands with bits below the rounding point. A wrong precision or exact-path select shows up in `flag_update` or in the low 29 bits of the result. The vectors therefore cover each rounding mode on both signs, ties to even, carries into the exponent, the extreme signed values, and zero at both widths.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_TO_PINF   = 2'b10,
    RM_TO_NINF   = 2'b11
  } rnd_mode_e;

  typedef enum logic [1:0] {
    IK_S32 = 2'd0,
    IK_U32 = 2'd1,
    IK_S64 = 2'd2,
    IK_U64 = 2'd3
  } int_kind_e;

  localparam logic [4:0] CLS_NONE     = 5'b00000;
  localparam logic [4:0] CLS_POS_NORM = 5'b01000;
  localparam logic [4:0] CLS_NEG_NORM = 5'b10000;
  localparam logic [4:0] CLS_POS_ZERO = 5'b00010;

  // Decide whether rounding adds one unit in the last place.
  function automatic logic round_incr(input logic [1:0] mode, input logic neg,
                                      input logic lsb, input logic grd,
                                      input logic rnd, input logic stk);
    logic lost;
    lost = grd | rnd | stk;
    unique case (mode)
      RM_NEAR_EVEN: round_incr = grd & (rnd | stk | lsb);
      RM_TO_ZERO:   round_incr = 1'b0;
      RM_TO_PINF:   round_incr = ~neg & lost;
      default:      round_incr = neg & lost;
    endcase
  endfunction

endpackage

// File: rtl/i2f_magnitude.sv
module i2f_magnitude #(
  parameter int XLEN = 64,
  parameter int HALF = XLEN / 2
) (
  input  logic [XLEN-1:0] src,
  input  logic [1:0]      kind,
  output logic            neg,
  output logic [XLEN-1:0] mag,
  output logic            is_zero
);
  logic            is_signed;
  logic            is_narrow;
  logic [XLEN-1:0] widened;

  always_comb begin
    is_signed = ~kind[0];
    is_narrow = ~kind[1];
    if (is_narrow) begin
      widened = is_signed ? {{(XLEN-HALF){src[HALF-1]}}, src[HALF-1:0]}
                          : {{(XLEN-HALF){1'b0}}, src[HALF-1:0]};
    end else begin
      widened = src;
    end
    neg     = is_signed & widened[XLEN-1];
    mag     = neg ? (~widened + {{(XLEN-1){1'b0}}, 1'b1}) : widened;
    is_zero = ~|widened;
  end

endmodule

// File: rtl/i2f_lead_norm.sv
module i2f_lead_norm #(
  parameter int XLEN = 64,
  parameter int LZW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] mag,
  output logic [LZW-1:0]  lead_pos,
  output logic [XLEN-1:0] norm
);
  localparam logic [LZW-1:0] TOP = LZW'(XLEN - 1);

  logic [LZW-1:0] shamt;

  // Priority encoder: the highest set bit wins.
  always_comb begin
    lead_pos = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (mag[i]) lead_pos = LZW'(i);
    end
    shamt = TOP - lead_pos;
    norm  = mag << shamt;
  end

endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int FRAC = 52,
  parameter int GIDX = XLEN - 2 - FRAC
) (
  input  logic [XLEN-2:0] norm_tail,
  input  logic            neg,
  input  logic [1:0]      mode,
  output logic [FRAC-1:0] frac,
  output logic            carry,
  output logic            inexact,
  output logic            rnd_up
);
  logic [FRAC-1:0] kept;
  logic            grd;
  logic            rnd;
  logic            stk;
  logic [FRAC:0]   sum;

  always_comb begin
    kept    = norm_tail[XLEN-2 -: FRAC];
    grd     = norm_tail[GIDX];
    rnd     = norm_tail[GIDX-1];
    stk     = |norm_tail[GIDX-2:0];
    inexact = grd | rnd | stk;
    rnd_up  = round_incr(mode, neg, kept[0], grd, rnd, stk);
    sum     = {1'b0, kept} + {{FRAC{1'b0}}, rnd_up};
    carry   = sum[FRAC];
    frac    = sum[FRAC-1:0];
  end

endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
  import i2f_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int DEXP  = 11,
  parameter int DFRAC = 52,
  parameter int SFRAC = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [63:0]     src_int,
  input  logic [1:0]      int_kind,
  input  logic            want_single,
  input  logic [1:0]      rnd_mode,
  output logic            out_valid,
  output logic [63:0]     res_fp,
  output logic            flag_inexact,
  output logic            flag_rnd_up,
  output logic [4:0]      res_class,
  output logic            flag_update
);
  localparam int LZW   = $clog2(XLEN);
  localparam int DBIAS = (1 << (DEXP - 1)) - 1;
  localparam int PAD   = DFRAC - SFRAC;
  localparam int NPREC = 2;

  logic            neg;
  logic [XLEN-1:0] mag;
  logic            is_zero;
  logic [LZW-1:0]  lead_pos;
  logic [XLEN-1:0] norm;

  i2f_magnitude #(.XLEN(XLEN)) u_mag (
    .src(src_int), .kind(int_kind), .neg(neg), .mag(mag), .is_zero(is_zero)
  );

  i2f_lead_norm #(.XLEN(XLEN)) u_norm (
    .mag(mag), .lead_pos(lead_pos), .norm(norm)
  );

  // Index 0 rounds at double precision, index 1 at single precision.
  logic [DFRAC-1:0] frac_w  [NPREC];
  logic             carry_w [NPREC];
  logic             nx_w    [NPREC];
  logic             up_w    [NPREC];

  for (genvar p = 0; p < NPREC; p++) begin : g_prec
    localparam int FW = (p == 0) ? DFRAC : SFRAC;
    logic [FW-1:0] frac_p;
    i2f_round #(.XLEN(XLEN), .FRAC(FW)) u_rnd (
      .norm_tail(norm[XLEN-2:0]), .neg(neg), .mode(rnd_mode),
      .frac(frac_p), .carry(carry_w[p]), .inexact(nx_w[p]), .rnd_up(up_w[p])
    );
    if (p == 0) begin : g_wide
      assign frac_w[p] = frac_p;
    end else begin : g_narrow
      assign frac_w[p] = {frac_p, {(DFRAC-FW){1'b0}}};
    end
  end

  // Next-state computation
  logic            sel;
  logic            exact_path;
  logic [DEXP-1:0] exp_n;
  logic [63:0]     fp_n;
  logic            nx_n;
  logic            up_n;
  logic [4:0]      cls_n;
  logic            upd_n;

  always_comb begin
    sel        = want_single;
    exact_path = ~int_kind[1] & ~want_single;
    exp_n      = DEXP'(DBIAS) + DEXP'(lead_pos) + DEXP'(carry_w[sel]);
    upd_n      = ~exact_path;
    if (is_zero) begin
      fp_n  = '0;
      nx_n  = 1'b0;
      up_n  = 1'b0;
      cls_n = exact_path ? CLS_NONE : CLS_POS_ZERO;
    end else begin
      fp_n  = {neg, exp_n, frac_w[sel]};
      nx_n  = exact_path ? 1'b0 : nx_w[sel];
      up_n  = exact_path ? 1'b0 : up_w[sel];
      cls_n = exact_path ? CLS_NONE : (neg ? CLS_NEG_NORM : CLS_POS_NORM);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_fp       <= '0;
      flag_inexact <= 1'b0;
      flag_rnd_up  <= 1'b0;
      res_class    <= '0;
      flag_update  <= 1'b0;
    end else if (in_valid) begin
      res_fp       <= fp_n;
      flag_inexact <= nx_n;
      flag_rnd_up  <= up_n;
      res_class    <= cls_n;
      flag_update  <= upd_n;
    end
  end

  // Assertions
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(res_fp) && !out_valid)); // R11
  AST_EXACT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !flag_update) |-> (!flag_inexact && !flag_rnd_up && res_class == CLS_NONE)); // R2
  AST_EXACT_SELECT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !int_kind[1] && !want_single) |=> !flag_update); // R2
  AST_ROUNDED_SELECT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (int_kind[1] || want_single)) |=> flag_update); // R3
  AST_SIGN_CLASS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && flag_update) |-> ((res_class == CLS_NEG_NORM) == res_fp[63])); // R3
  AST_SINGLE_WIDE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && want_single) |=> (res_fp[PAD-1:0] == '0)); // R5
  AST_TRUNC_NO_UP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && rnd_mode == RM_TO_ZERO) |=> !flag_rnd_up); // R6
  AST_UP_IMPLIES_NX: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && flag_rnd_up) |-> flag_inexact); // R7
  AST_ZERO_PLUS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (int_kind[1] ? (src_int == 64'd0) : (src_int[31:0] == 32'd0))) |=> (res_fp == 64'd0 && !flag_inexact)); // R9

endmodule

// File: tb/tb_i2f_convert.sv
module tb_i2f_convert;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] src_int;
  logic [1:0]  int_kind;
  logic        want_single;
  logic [1:0]  rnd_mode;
  logic        out_valid;
  logic [63:0] res_fp;
  logic        flag_inexact;
  logic        flag_rnd_up;
  logic [4:0]  res_class;
  logic        flag_update;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  i2f_convert dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_int(src_int),
    .int_kind(int_kind), .want_single(want_single), .rnd_mode(rnd_mode),
    .out_valid(out_valid), .res_fp(res_fp), .flag_inexact(flag_inexact),
    .flag_rnd_up(flag_rnd_up), .res_class(res_class), .flag_update(flag_update)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic [63:0] src;
    logic [1:0]  kind;
    logic        sgl;
    logic [1:0]  rm;
    logic [63:0] fp;
    logic        nx;
    logic        up;
    logic [4:0]  cls;
    logic        upd;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{64'h0000000000000001, 2'd0, 1'b0, 2'd0, 64'h3FF0000000000000, 1'b0, 1'b0, 5'h00, 1'b0}, // R2 exact +1
    '{64'hDEADBEEFFFFFFFFF, 2'd0, 1'b0, 2'd0, 64'hBFF0000000000000, 1'b0, 1'b0, 5'h00, 1'b0}, // R1 upper ignored
    '{64'h12345678FFFFFFFF, 2'd1, 1'b0, 2'd0, 64'h41EFFFFFFFE00000, 1'b0, 1'b0, 5'h00, 1'b0}, // R1 unsigned 32
    '{64'h0000000000000001, 2'd0, 1'b1, 2'd0, 64'h3FF0000000000000, 1'b0, 1'b0, 5'h08, 1'b1}, // R5 single exact
    '{64'h00000000FFFFFFFF, 2'd1, 1'b1, 2'd0, 64'h41F0000000000000, 1'b1, 1'b1, 5'h08, 1'b1}, // R8 carry
    '{64'h00000000FFFFFFFF, 2'd1, 1'b1, 2'd1, 64'h41EFFFFFE0000000, 1'b1, 1'b0, 5'h08, 1'b1}, // R6 toward zero
    '{64'h00000000FFFFFFFF, 2'd1, 1'b1, 2'd2, 64'h41F0000000000000, 1'b1, 1'b1, 5'h08, 1'b1}, // R6 +inf
    '{64'h00000000FFFFFFFF, 2'd1, 1'b1, 2'd3, 64'h41EFFFFFE0000000, 1'b1, 1'b0, 5'h08, 1'b1}, // R6 -inf
    '{64'h0000000080000001, 2'd0, 1'b1, 2'd3, 64'hC1E0000000000000, 1'b1, 1'b1, 5'h10, 1'b1}, // R6 -inf neg
    '{64'h0000000080000001, 2'd0, 1'b1, 2'd1, 64'hC1DFFFFFE0000000, 1'b1, 1'b0, 5'h10, 1'b1}, // R6 RZ neg
    '{64'h0020000000000001, 2'd3, 1'b0, 2'd0, 64'h4340000000000000, 1'b1, 1'b0, 5'h08, 1'b1}, // R4 tie even down
    '{64'h0020000000000003, 2'd3, 1'b0, 2'd0, 64'h4340000000000002, 1'b1, 1'b1, 5'h08, 1'b1}, // R4 tie even up
    '{64'h8000000000000000, 2'd2, 1'b0, 2'd0, 64'hC3E0000000000000, 1'b0, 1'b0, 5'h10, 1'b1}, // R10 min s64
    '{64'h5555555580000000, 2'd0, 1'b0, 2'd0, 64'hC1E0000000000000, 1'b0, 1'b0, 5'h00, 1'b0}, // R10 min s32
    '{64'h0000000000000000, 2'd2, 1'b0, 2'd0, 64'h0000000000000000, 1'b0, 1'b0, 5'h02, 1'b1}, // R9 zero 64
    '{64'hFFFFFFFF00000000, 2'd0, 1'b0, 2'd2, 64'h0000000000000000, 1'b0, 1'b0, 5'h00, 1'b0}, // R9 zero 32
    '{64'hFFFFFFFFFFFFFFFF, 2'd2, 1'b0, 2'd0, 64'hBFF0000000000000, 1'b0, 1'b0, 5'h10, 1'b1}, // R3 -1 s64
    '{64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b0, 2'd0, 64'h43F0000000000000, 1'b1, 1'b1, 5'h08, 1'b1}, // R8 u64 max
    '{64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b0, 2'd1, 64'h43EFFFFFFFFFFFFF, 1'b1, 1'b0, 5'h08, 1'b1}, // R4 u64 max RZ
    '{64'hA5A5A5A500000003, 2'd1, 1'b1, 2'd0, 64'h4008000000000000, 1'b0, 1'b0, 5'h08, 1'b1}, // R1 single u32
    '{64'hFFFFFFFFFFFFFFFD, 2'd2, 1'b1, 2'd2, 64'hC008000000000000, 1'b0, 1'b0, 5'h10, 1'b1}  // R7 exact no flags
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] s, input logic [1:0] k, input logic sg, input logic [1:0] m);
    @(negedge clk);
    src_int     = s;
    int_kind    = k;
    want_single = sg;
    rnd_mode    = m;
    in_valid    = 1'b1;
    @(negedge clk);
    in_valid    = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  logic [63:0] held;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_int = '0; int_kind = '0;
    want_single = 1'b0; rnd_mode = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset valid", 64'(out_valid), 64'd0);
    check("R11 reset result", res_fp, 64'd0);
    check("R11 reset flags", {59'd0, flag_inexact, flag_rnd_up, flag_update, 2'b00}, 64'd0);
    check("R11 reset class", 64'(res_class), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].src, VEC[i].kind, VEC[i].sgl, VEC[i].rm);
      check("R11 valid", 64'(out_valid), 64'd1);
      check("R4/R5 result", res_fp, VEC[i].fp);
      check("R7 inexact", 64'(flag_inexact), 64'(VEC[i].nx));
      check("R7 rounded up", 64'(flag_rnd_up), 64'(VEC[i].up));
      check("R3 class", 64'(res_class), 64'(VEC[i].cls));
      check("R2 update", 64'(flag_update), 64'(VEC[i].upd));
    end

    // R11 hold: inputs change without a request, outputs stay
    held = res_fp;
    @(negedge clk);
    src_int = 64'h0000000000000007; int_kind = 2'd3; rnd_mode = 2'd2;
    @(negedge clk);
    check("R11 idle valid", 64'(out_valid), 64'd0);
    check("R11 idle hold", res_fp, held);

    // R1: upper half garbage differs, same low half, same result
    apply(64'h0000000000000005, 2'd0, 1'b1, 2'd0);
    held = res_fp;
    apply(64'hFFFF0000FFFF0005 & 64'hFFFFFFFF00000005, 2'd0, 1'b1, 2'd0);
    check("R1 upper half ignored", res_fp, held);
    check("R1 value five", held, 64'h4014000000000000);

    // R5 single rounding of a 64-bit source with sticky only: 2^40+1
    apply(64'h0000010000000001, 2'd3, 1'b1, 2'd2);
    check("R5 single +inf sticky", res_fp, 64'h4270000020000000);
    check("R7 sticky inexact", 64'(flag_inexact), 64'd1);

    // R10 min s64 in single precision
    apply(64'h8000000000000000, 2'd2, 1'b1, 2'd3);
    check("R10 min s64 single", res_fp, 64'hC3E0000000000000);

    summary();
  end

endmodule